// File: doc/BRIEF.md
# Single-Line NMI Controller

This block conditions one external non-maskable interrupt line for a parent interrupt controller. The raw line is brought into the clock domain by a flop chain. A software-chosen trigger rule then turns the line into events: active-high level, active-low level, rising edge or falling edge. Each event sets a sticky pending flag. The pending flag is ANDed with an enable bit, and the result is registered to drive a single interrupt output.

Software reaches three registers through a plain single-cycle register port. The write strobe commits on the clock edge, and read data is combinational from the address. The registers are a control word whose low two bits hold the trigger rule, a pending flag cleared by writing one, and an enable flag. A build parameter selects one of three offset layouts, so the same block fits several address maps.

Top module: `nmi_line_top`

## Requirements
- R1: After reset, the control word reads 0 (active-low level mode), pending reads 0, enable reads 0, and `irqOut` is 0.
- R2: Control bits [1:0] select the trigger rule: 0 = line low (level), 1 = high-to-low transition, 2 = line high (level), 3 = low-to-high transition. An input activity that does not match the selected rule does not set pending.
- R3: A write to the control offset stores the whole data word, and it reads back unchanged. Bits above [1:0] have no effect on triggering.
- R4: In the two edge modes, a matching transition sets pending (bit 0 of the pending register). Pending then stays set, whatever the line does, until software clears it.
- R5: Writing a word with bit 0 = 1 to the pending offset clears pending when no event occurs in that cycle. Writing bit 0 = 0 leaves pending unchanged.
- R6: In the two level modes, pending is set in every cycle in which the synchronised line is at its active level. A clear issued while the line is still active therefore leaves pending set.
- R7: When a trigger event and a pending clear fall in the same cycle, the event wins and pending stays 1.
- R8: Bit 0 of the enable register gates the output. `irqOut` equals (pending AND enable) as it was one clock earlier.
- R9: A change on `nmiIn` that is applied before clock edge k first shows as pending = 1 after edge k+2. It is not visible after edge k+1.
- R10: `LAYOUT` selects the offsets of control, pending and enable: 0 selects 0x00, 0x04 and 0x34; 1 selects 0x00, 0x04 and 0x08; 2 selects 0x00, 0x08 and 0x04.
- R11: Reads from any offset that the layout does not map return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiIn | input | 1 | Raw, asynchronous interrupt line |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Write strobe, committed at the rising clock edge |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for `busAddr` |
| irqOut | output | 1 | Registered interrupt request to the parent controller |

## Verification
The assertions check the cycle-level rules on every clock: the registered gating of the output, the stickiness of pending, transition and level setting, clear-versus-event ordering, and zero read data at unmapped offsets. Only the bench scenarios can show the things that need a sequence of events. These are the exact synchroniser latency, the rejection of activity that does not match the selected mode, the read-back of the spare control bits, and the offsets of the selected layout. They also include writes to holes in the address map leaving every register untouched.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH  = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  // Strobes from the address decoder to the datapath.
  typedef struct packed {
    logic ctrlWr;
    logic enWr;
    logic pendClr;
    logic ctrlSel;
    logic enSel;
    logic pendSel;
  } regStrobe_t;

  function automatic int ctrlOffset(int layout);
    return (layout >= 0) ? 'h00 : 'h00;
  endfunction

  function automatic int pendOffset(int layout);
    return (layout == 2) ? 'h08 : 'h04;
  endfunction

  function automatic int enOffset(int layout);
    case (layout)
      0:       return 'h34;
      1:       return 'h08;
      default: return 'h04;
    endcase
  endfunction

endpackage

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              wrBit0,
  output regStrobe_t        strb
);

  localparam int CTRL_OFF = ctrlOffset(LAYOUT);
  localparam int PEND_OFF = pendOffset(LAYOUT);
  localparam int EN_OFF   = enOffset(LAYOUT);

  logic hitCtrl, hitPend, hitEn;

  assign hitCtrl = (busAddr == CTRL_OFF[ADDR_W-1:0]);
  assign hitPend = (busAddr == PEND_OFF[ADDR_W-1:0]);
  assign hitEn   = (busAddr == EN_OFF[ADDR_W-1:0]);

  always_comb begin
    strb         = '0;
    strb.ctrlSel = hitCtrl;
    strb.pendSel = hitPend;
    strb.enSel   = hitEn;
    strb.ctrlWr  = busWrEn && hitCtrl;
    strb.enWr    = busWrEn && hitEn;
    strb.pendClr = busWrEn && hitPend && wrBit0;
  end

endmodule

// File: rtl/nmi_line_dp.sv
module nmi_line_dp
  import nmi_line_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiIn,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              pendQ,
  output logic              enQ,
  output logic [1:0]        modeQ,
  output logic              syncVal,
  output logic              syncPrev
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_W-1:0]      ctrlQ;
  logic                   evt;
  trig_e                  mode;

  // Line synchroniser, idle-high after reset.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= nmiIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], nmiIn};
    end
  endgenerate

  assign syncVal = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncPrev <= 1'b1;
    else       syncPrev <= syncVal;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            ctrlQ <= '0;
    else if (strb.ctrlWr) ctrlQ <= wrData;

  assign modeQ = ctrlQ[1:0];
  assign mode  = trig_e'(ctrlQ[1:0]);

  always_comb begin
    case (mode)
      TRIG_LVL_LOW:   evt = !syncVal;
      TRIG_EDGE_FALL: evt = syncPrev && !syncVal;
      TRIG_LVL_HIGH:  evt = syncVal;
      default:        evt = !syncPrev && syncVal;
    endcase
  end

  // A new event has priority over a software clear.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             pendQ <= 1'b0;
    else if (evt)          pendQ <= 1'b1;
    else if (strb.pendClr) pendQ <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          enQ <= 1'b0;
    else if (strb.enWr) enQ <= wrData[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= pendQ && enQ;

  always_comb begin
    rdData = '0;
    if (strb.ctrlSel) rdData = ctrlQ;
    if (strb.pendSel) rdData[0] = pendQ;
    if (strb.enSel)   rdData[0] = enQ;
  end

endmodule

// File: rtl/nmi_line_top.sv
module nmi_line_top
  import nmi_line_pkg::*;
#(
  parameter int LAYOUT      = 0,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  regStrobe_t strb;
  logic       pendQ, enQ, syncVal, syncPrev, pendClrS;
  logic [1:0] modeQ;

  nmi_line_ctrl #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .wrBit0 (busWrData[0]),
    .strb   (strb)
  );

  nmi_line_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .nmiIn   (nmiIn),
    .strb    (strb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .pendQ   (pendQ),
    .enQ     (enQ),
    .modeQ   (modeQ),
    .syncVal (syncVal),
    .syncPrev(syncPrev)
  );

  assign pendClrS = strb.pendClr;

endmodule

// File: rtl/nmi_line_chk.sv
module nmi_line_chk
  import nmi_line_pkg::*;
#(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqOut,
  input logic              pendQ,
  input logic              enQ,
  input logic [1:0]        modeQ,
  input logic              syncVal,
  input logic              syncPrev,
  input logic              pendClr
);

  localparam int C_OFF = ctrlOffset(LAYOUT);
  localparam int P_OFF = pendOffset(LAYOUT);
  localparam int E_OFF = enOffset(LAYOUT);

  logic chkEvt, mapped;

  always_comb begin
    chkEvt = 1'b0;
    if (modeQ == 2'd0 && !syncVal)             chkEvt = 1'b1;
    if (modeQ == 2'd1 && syncPrev && !syncVal) chkEvt = 1'b1;
    if (modeQ == 2'd2 && syncVal)              chkEvt = 1'b1;
    if (modeQ == 2'd3 && !syncPrev && syncVal) chkEvt = 1'b1;
  end

  assign mapped = (busAddr == C_OFF[ADDR_W-1:0]) || (busAddr == P_OFF[ADDR_W-1:0]) ||
                  (busAddr == E_OFF[ADDR_W-1:0]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(pendQ && enQ)));

  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd3 && syncVal && !syncPrev) |=> pendQ);

  p_fall_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd1 && !syncVal && syncPrev) |=> pendQ);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !pendClr) |=> pendQ);

  p_level_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd2 && syncVal) |=> pendQ);

  p_level_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd0 && !syncVal) |=> pendQ);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr && !chkEvt) |=> !pendQ);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr && chkEvt) |=> pendQ);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (busRdData == '0));

endmodule

bind nmi_line_top nmi_line_chk #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .pendQ    (pendQ),
  .enQ      (enQ),
  .modeQ    (modeQ),
  .syncVal  (syncVal),
  .syncPrev (syncPrev),
  .pendClr  (pendClrS)
);

// File: tb/nmi_line_top_test.sv
`timescale 1ns/10ps
module nmi_line_top_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  // Offsets of layout 0, taken from R10.
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_PEND = 8'h04;
  localparam logic [7:0] A_EN   = 8'h34;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              nmiIn = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              irqOut;

  typedef struct {
    bit                isIrq;
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  nmi_line_top #(.LAYOUT(0)) uut (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // Monitor: compares each expected item as the design presents it.
  initial begin
    forever begin
      wait (expQ.size() > 0);
      #0.1;
      begin
        item_t it;
        logic [DATA_W-1:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {{(DATA_W-1){1'b0}}, irqOut} : busRdData;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkRd(input logic [7:0] a, input logic [DATA_W-1:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.isIrq = 0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    item_t it;
    it.isIrq = 1; it.exp = {{(DATA_W-1){1'b0}}, e}; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // Starts at a falling edge, commits at the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chkRd(A_CTRL, 32'h0, "R1 ctrl");
    chkRd(A_PEND, 32'h0, "R1 pend");
    chkRd(A_EN,   32'h0, "R1 en");
    chkIrq(1'b0, "R1 irq");
    tick(1);

    // R11 / R10: holes in the layout-0 map
    wr(8'h08, 32'hFFFF_FFFF);
    chkRd(8'h08, 32'h0, "R11 read hole 0x08");
    chkRd(A_EN, 32'h0, "R11 hole write left enable");
    chkRd(A_CTRL, 32'h0, "R11 hole write left ctrl");
    chkRd(8'h10, 32'h0, "R11 read hole 0x10");
    wr(A_EN, 32'h1);
    chkRd(A_EN, 32'h1, "R10 enable at 0x34");
    chkIrq(1'b0, "R8 irq masked by idle pending");

    // Level-low mode (code 0)
    nmiIn = 1'b0;
    tick(2);
    chkRd(A_PEND, 32'h0, "R9 not visible after two edges");
    tick(1);
    chkRd(A_PEND, 32'h1, "R2 R9 level low sets pending");
    chkIrq(1'b0, "R8 irq one cycle behind pending");
    tick(1);
    chkIrq(1'b1, "R8 irq asserted");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h1, "R6 clear while line active");
    nmiIn = 1'b1;
    tick(4);
    chkRd(A_PEND, 32'h1, "R6 pending kept after line inactive");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h0, "R5 clear");
    tick(1);
    chkIrq(1'b0, "R8 irq drops after clear");

    // Rising-edge mode (code 3) with spare bits
    wr(A_CTRL, 32'h5A5A_00A7);
    chkRd(A_CTRL, 32'h5A5A_00A7, "R3 ctrl readback");
    nmiIn = 1'b0;
    tick(4);
    chkRd(A_PEND, 32'h0, "R2 falling ignored in rising mode");
    nmiIn = 1'b1;
    tick(3);
    chkRd(A_PEND, 32'h1, "R4 rising edge sets pending");
    nmiIn = 1'b0;
    tick(4);
    chkRd(A_PEND, 32'h1, "R4 pending sticky");
    wr(A_PEND, 32'h0);
    chkRd(A_PEND, 32'h1, "R5 write zero ignored");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h0, "R5 clear in edge mode");
    // R7: clear commits on the same edge the rising event is detected
    nmiIn = 1'b1;
    tick(2);
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h1, "R7 event beats clear");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h0, "R4 clear with steady line");

    // Falling-edge mode (code 1)
    wr(A_CTRL, 32'h1);
    tick(3);
    chkRd(A_PEND, 32'h0, "R2 steady high in falling mode");
    nmiIn = 1'b0;
    tick(3);
    chkRd(A_PEND, 32'h1, "R2 falling edge sets pending");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h0, "R4 falling clear");

    // Level-high mode (code 2)
    wr(A_CTRL, 32'h2);
    tick(3);
    chkRd(A_PEND, 32'h0, "R2 low line in level-high mode");
    nmiIn = 1'b1;
    tick(3);
    chkRd(A_PEND, 32'h1, "R2 level high sets pending");
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h1, "R6 level high re-sets");
    wr(A_EN, 32'h0);
    tick(1);
    chkIrq(1'b0, "R8 enable zero masks output");
    chkRd(A_PEND, 32'h1, "R8 mask keeps pending");
    nmiIn = 1'b0;
    tick(3);
    wr(A_PEND, 32'h1);
    chkRd(A_PEND, 32'h0, "R6 clear after line drops");

    tick(2);
    wait (expQ.size() == 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule